// File: doc/BRIEF.md
# Paged NIC Host Register Bank

This block is the byte-wide register file through which a host processor configures and services a legacy Ethernet controller. The host presents a 4-bit address together with a write strobe or a read. Address 0 always reaches the command register. Every other address is combined with a two-bit page number, held in the top of the command register, to pick one of several register pages. The block holds the ring buffer page pointers, the transmit page and length, the remote DMA address and length, the receive and data mode bytes, the station address, the multicast hash filter, and the interrupt status and mask registers.

Command writes have side effects. A transmit command is acknowledged at once: it raises a one-cycle request toward the transmit engine, writes a success code into the transmit status and raises the transmit-done status bit. A remote DMA command with a zero byte count completes at once. A remote DMA command with a nonzero count starts the external DMA engine with a pulse. The receive and DMA datapaths sit outside the block. They report completion through two side-band event inputs, and they read their configuration from the block's output ports. A single level-sensitive interrupt line reflects the enabled status bits.

Top module: `nic_reg_bank`

## Requirements
- R1: After the active-low reset the command register reads 0x01 (stop set, page 0), the interrupt status reads 0x80, `irq` is low, and all other registers and configuration outputs are 0.
- R2: Address 0 reads and writes the command register on every page. For any other address the register index is {command[7:6], host_addr}, so the register reached is chosen by the page held in command bits 7:6.
- R3: `irq` is high exactly when (status AND mask) is nonzero in bits 6:0. Status bit 7 never raises `irq`.
- R4: A write to index 0x07 clears each status bit in 6:0 whose written bit is 1 and leaves every other bit as it was. Bit 7 cannot be cleared this way.
- R5: A command write with bit 0 clear clears status bit 7. A command write with bit 0 set leaves status bit 7 as it was.
- R6: A command write with bit 0 clear and either bit 3 or bit 4 set, while the remote length (indices 0x0A/0x0B) is zero, sets status bit 6 in the next cycle. If the length is nonzero it leaves bit 6 alone and pulses `rdma_start` high for one cycle.
- R7: A command write with bit 0 clear and bit 2 set pulses `tx_req` for one cycle. It also sets the transmit status (read at index 0x04) to 0x01 and sets status bit 1. Command bit 2 then reads back as 0.
- R8: A write of page value v is dropped at indices 0x01 (ring start) and 0x02 (ring stop) when v > PMEM_END_PG. It is dropped at indices 0x03 (boundary) and 0x17 (current page) when v >= PMEM_END_PG.
- R9: On page 0, indices 0x0A and 0x0B read the identity bytes 0x50 and 0x43. On page 2, indices 0x21 and 0x22 read back the ring start and ring stop pages.
- R10: The transmit length (low 0x05, high 0x06), remote address (low 0x08, high 0x09) and remote length (low 0x0A, high 0x0B) are 16-bit values written one byte at a time. Each byte write changes only its own half. The remote address reads back at 0x08/0x09.
- R11: Indices 0x11 to 0x16 hold station address bytes 0 to 5, and indices 0x18 to 0x1F hold hash bytes 0 to 7. All of them read back. Byte k appears at bits 8k+7:8k of `station_addr` and `mcast_hash`.
- R12: A high `rx_ok` sets status bit 0 and a high `rdma_done` sets status bit 6 in the next cycle. A set takes priority over a host clear of the same bit in the same cycle.
- R13: A read of any index with no register behind it returns 0x00, including every nonzero address on page 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 4 | Register address within the current page |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| irq | output | 1 | Level interrupt |
| rx_ok | input | 1 | Receive engine event: frame stored |
| rdma_done | input | 1 | DMA engine event: transfer complete |
| tx_req | output | 1 | One-cycle transmit request |
| rdma_start | output | 1 | One-cycle remote DMA start |
| ring_start_pg | output | 8 | Ring start page |
| ring_stop_pg | output | 8 | Ring stop page |
| bound_pg | output | 8 | Ring boundary page |
| cur_pg | output | 8 | Ring current page |
| tx_pg | output | 8 | Transmit start page |
| tx_len | output | 16 | Transmit byte count |
| rdma_addr | output | 16 | Remote DMA start address |
| rdma_len | output | 16 | Remote DMA byte count |
| rx_mode | output | 8 | Receive configuration byte |
| data_mode | output | 8 | Data configuration byte |
| station_addr | output | 48 | Station address, byte k at bits 8k+7:8k |
| mcast_hash | output | 64 | Multicast hash filter, byte k at bits 8k+7:8k |

## Verification
The assertions assume that `host_wr` is a single-cycle strobe. They also assume that `rx_ok` and `rdma_done` are synchronous to `clk` and never unknown once reset is released. The bench drives every input at the falling edge, so each write lands at exactly one rising edge. It holds the side-band events high for one cycle at a time. It raises a host clear and an event together only in the one case that tests their priority. Page changes are always made through a command write before the register accesses that depend on them, so each check knows which page is selected.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // command bit positions
   localparam int CMD_STOP = 0;
   localparam int CMD_TX   = 2;
   localparam int CMD_RRD  = 3;
   localparam int CMD_RWR  = 4;

   // interrupt status bit positions
   localparam int ST_RX    = 0;
   localparam int ST_TX    = 1;
   localparam int ST_RDC   = 6;
   localparam int ST_RST   = 7;

   localparam byte_t CMD_RESET = 8'h01;
   localparam byte_t ST_RESET  = 8'h80;
   localparam byte_t TSR_OK    = 8'h01;
   localparam byte_t ST_CLR_MASK = 8'h7F;

   // register index map: {page, addr}
   localparam logic [5:0] IX_START = 6'h01;
   localparam logic [5:0] IX_STOP  = 6'h02;
   localparam logic [5:0] IX_BND   = 6'h03;
   localparam logic [5:0] IX_TPG   = 6'h04;
   localparam logic [5:0] IX_TLEN0 = 6'h05;
   localparam logic [5:0] IX_TLEN1 = 6'h06;
   localparam logic [5:0] IX_STAT  = 6'h07;
   localparam logic [5:0] IX_RADR0 = 6'h08;
   localparam logic [5:0] IX_RADR1 = 6'h09;
   localparam logic [5:0] IX_RLEN0 = 6'h0A;
   localparam logic [5:0] IX_RLEN1 = 6'h0B;
   localparam logic [5:0] IX_RXM   = 6'h0C;
   localparam logic [5:0] IX_DATM  = 6'h0E;
   localparam logic [5:0] IX_MASK  = 6'h0F;
   localparam logic [5:0] IX_CUR   = 6'h17;
   localparam logic [5:0] IX_RSTART = 6'h21;
   localparam logic [5:0] IX_RSTOP  = 6'h22;
endpackage

// File: rtl/nic_page_reg.sv
module nic_page_reg #(
   parameter int W         = 8,
   parameter int LIMIT     = 128,
   parameter bit INCLUSIVE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic ok;

   generate
      if (INCLUSIVE) begin : g_incl
         assign ok = (int'(wdata) <= LIMIT);
      end else begin : g_excl
         assign ok = (int'(wdata) < LIMIT);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (we && ok)  q <= wdata;
   end

   // a page value beyond the memory end leaves the register untouched
   assert_page_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (INCLUSIVE ? (int'(wdata) > LIMIT) : (int'(wdata) >= LIMIT))) |=> $stable(q));
endmodule

// File: rtl/nic_split_reg.sv
module nic_split_reg #(
   parameter int BYTES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BYTES-1:0]     we,
   input  logic [7:0]           wdata,
   output logic [BYTES*8-1:0]   q
);
   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[b*8 +: 8] <= 8'h00;
         else if (we[b]) q[b*8 +: 8] <= wdata;
      end

      // a byte not addressed keeps its value
      assert_half_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !we[b] |=> $stable(q[b*8 +: 8]));
   end
endmodule

// File: rtl/nic_byte_array.sv
module nic_byte_array #(
   parameter int N  = 6,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IW-1:0]   sel,
   input  logic [7:0]      wdata,
   output logic [N*8-1:0]  q
);
   if (N < 1) begin : g_bad_n
      $error("nic_byte_array: N must be at least 1");
   end

   for (genvar k = 0; k < N; k++) begin : g_ent
      logic hit;
      assign hit = we && (sel == IW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q[k*8 +: 8] <= 8'h00;
         else if (hit) q[k*8 +: 8] <= wdata;
      end
   end
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
   import nic_reg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   we,
   input  byte_t  wdata,
   input  logic   count_zero,
   output byte_t  cmd_q,
   output byte_t  tsr_q,
   output logic   tx_req,
   output logic   rdma_start,
   output byte_t  set_bits,
   output logic   clr_reset_bit
);
   logic go, tx_go, rem_go;

   assign go     = we && !wdata[CMD_STOP];
   assign tx_go  = go && wdata[CMD_TX];
   assign rem_go = go && (wdata[CMD_RRD] || wdata[CMD_RWR]);

   always_comb begin
      set_bits         = '0;
      set_bits[ST_TX]  = tx_go;
      set_bits[ST_RDC] = rem_go && count_zero;
   end
   assign clr_reset_bit = go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q      <= CMD_RESET;
         tsr_q      <= '0;
         tx_req     <= 1'b0;
         rdma_start <= 1'b0;
      end else begin
         tx_req     <= tx_go;
         rdma_start <= rem_go && !count_zero;
         if (we) begin
            cmd_q <= wdata;
            if (tx_go) cmd_q[CMD_TX] <= 1'b0;
         end
         if (tx_go) tsr_q <= TSR_OK;
      end
   end

   // transmit is acknowledged in the same cycle the request pulses
   assert_tx_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (!cmd_q[CMD_TX] && tsr_q == TSR_OK));
   assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wdata[CMD_STOP] && wdata[CMD_TX]) |=> tx_req);
   // DMA start only for a nonzero length
   assert_dma_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rdma_start |-> $past(!count_zero));
endmodule

// File: rtl/nic_intr.sv
module nic_intr
   import nic_reg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  byte_t  set_bits,
   input  byte_t  clr_bits,
   input  logic   mask_we,
   input  byte_t  wdata,
   output byte_t  stat_q,
   output byte_t  mask_q,
   output logic   irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= ST_RESET;
         mask_q <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_bits) | set_bits;
         if (mask_we) mask_q <= wdata;
      end
   end

   assign irq = |(stat_q[6:0] & mask_q[6:0]);

   // a clear without a competing set empties the bit
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_bits & ~set_bits) != 8'h00) |=> ((stat_q & $past(clr_bits & ~set_bits)) == 8'h00));
   // reset-complete bit alone never interrupts
   assert_bit7_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[6:0] == 7'd0) |-> !irq);
   // reset-complete bit is only ever made by reset
   assert_bit7_norise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(stat_q[ST_RST]));
endmodule

// File: rtl/nic_reg_bank.sv
module nic_reg_bank
   import nic_reg_pkg::*;
#(
   parameter int    PMEM_END_PG = 128,
   parameter int    STA_BYTES   = 6,
   parameter int    HASH_BYTES  = 8,
   parameter logic [7:0] ID0_VAL = 8'h50,
   parameter logic [7:0] ID1_VAL = 8'h43
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [3:0]              host_addr,
   input  logic                    host_wr,
   input  logic [7:0]              host_wdata,
   output logic [7:0]              host_rdata,
   output logic                    irq,
   input  logic                    rx_ok,
   input  logic                    rdma_done,
   output logic                    tx_req,
   output logic                    rdma_start,
   output logic [7:0]              ring_start_pg,
   output logic [7:0]              ring_stop_pg,
   output logic [7:0]              bound_pg,
   output logic [7:0]              cur_pg,
   output logic [7:0]              tx_pg,
   output logic [15:0]             tx_len,
   output logic [15:0]             rdma_addr,
   output logic [15:0]             rdma_len,
   output logic [7:0]              rx_mode,
   output logic [7:0]              data_mode,
   output logic [STA_BYTES*8-1:0]  station_addr,
   output logic [HASH_BYTES*8-1:0] mcast_hash
);
   localparam int SEL_W = 3;

   if (PMEM_END_PG < 1 || PMEM_END_PG > 255) begin : g_bad_end
      $error("nic_reg_bank: PMEM_END_PG out of range");
   end
   if (STA_BYTES != 6 || HASH_BYTES != 8) begin : g_bad_arr
      $error("nic_reg_bank: station/hash sizes fixed by the page map");
   end

   byte_t      cmd_q, tsr_q, stat_q, mask_q, cmd_set;
   byte_t      set_bits, clr_bits;
   logic       cmd_we, reg_we, clr_rst;
   logic [5:0] idx;

   assign cmd_we = host_wr && (host_addr == 4'h0);
   assign reg_we = host_wr && (host_addr != 4'h0);
   assign idx    = {cmd_q[7:6], host_addr};

   function automatic logic hit(input logic [5:0] a, input logic [5:0] b);
      return a == b;
   endfunction

   // ---------------- command ----------------
   nic_cmd_ctrl u_cmd (
      .clk           (clk),
      .rst_n         (rst_n),
      .we            (cmd_we),
      .wdata         (host_wdata),
      .count_zero    (rdma_len == 16'h0000),
      .cmd_q         (cmd_q),
      .tsr_q         (tsr_q),
      .tx_req        (tx_req),
      .rdma_start    (rdma_start),
      .set_bits      (cmd_set),
      .clr_reset_bit (clr_rst)
   );

   // ---------------- interrupt ----------------
   always_comb begin
      set_bits         = cmd_set;
      set_bits[ST_RX]  = cmd_set[ST_RX] | rx_ok;
      set_bits[ST_RDC] = cmd_set[ST_RDC] | rdma_done;
      clr_bits         = '0;
      if (reg_we && hit(idx, IX_STAT)) clr_bits = host_wdata & ST_CLR_MASK;
      clr_bits[ST_RST] = clr_rst;
   end

   nic_intr u_intr (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (set_bits),
      .clr_bits (clr_bits),
      .mask_we  (reg_we && hit(idx, IX_MASK)),
      .wdata    (host_wdata),
      .stat_q   (stat_q),
      .mask_q   (mask_q),
      .irq      (irq)
   );

   // ---------------- ring page pointers ----------------
   nic_page_reg #(.LIMIT(PMEM_END_PG), .INCLUSIVE(1'b1)) u_start (
      .clk(clk), .rst_n(rst_n), .we(reg_we && hit(idx, IX_START)),
      .wdata(host_wdata), .q(ring_start_pg));
   nic_page_reg #(.LIMIT(PMEM_END_PG), .INCLUSIVE(1'b1)) u_stop (
      .clk(clk), .rst_n(rst_n), .we(reg_we && hit(idx, IX_STOP)),
      .wdata(host_wdata), .q(ring_stop_pg));
   nic_page_reg #(.LIMIT(PMEM_END_PG), .INCLUSIVE(1'b0)) u_bnd (
      .clk(clk), .rst_n(rst_n), .we(reg_we && hit(idx, IX_BND)),
      .wdata(host_wdata), .q(bound_pg));
   nic_page_reg #(.LIMIT(PMEM_END_PG), .INCLUSIVE(1'b0)) u_cur (
      .clk(clk), .rst_n(rst_n), .we(reg_we && hit(idx, IX_CUR)),
      .wdata(host_wdata), .q(cur_pg));

   // ---------------- split 16-bit values ----------------
   nic_split_reg #(.BYTES(2)) u_tlen (
      .clk(clk), .rst_n(rst_n),
      .we({reg_we && hit(idx, IX_TLEN1), reg_we && hit(idx, IX_TLEN0)}),
      .wdata(host_wdata), .q(tx_len));
   nic_split_reg #(.BYTES(2)) u_radr (
      .clk(clk), .rst_n(rst_n),
      .we({reg_we && hit(idx, IX_RADR1), reg_we && hit(idx, IX_RADR0)}),
      .wdata(host_wdata), .q(rdma_addr));
   nic_split_reg #(.BYTES(2)) u_rlen (
      .clk(clk), .rst_n(rst_n),
      .we({reg_we && hit(idx, IX_RLEN1), reg_we && hit(idx, IX_RLEN0)}),
      .wdata(host_wdata), .q(rdma_len));

   // ---------------- plain bytes ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_pg     <= '0;
         rx_mode   <= '0;
         data_mode <= '0;
      end else if (reg_we) begin
         if (hit(idx, IX_TPG))  tx_pg     <= host_wdata;
         if (hit(idx, IX_RXM))  rx_mode   <= host_wdata;
         if (hit(idx, IX_DATM)) data_mode <= host_wdata;
      end
   end

   // ---------------- page 1 arrays ----------------
   logic sta_win, hash_win;
   logic [SEL_W-1:0] sta_sel;
   assign sta_win  = (cmd_q[7:6] == 2'b01) && (host_addr >= 4'h1) && (host_addr <= 4'h6);
   assign hash_win = (cmd_q[7:6] == 2'b01) && host_addr[3];
   assign sta_sel  = host_addr[2:0] - 3'd1;

   nic_byte_array #(.N(STA_BYTES)) u_sta (
      .clk(clk), .rst_n(rst_n), .we(reg_we && sta_win), .sel(sta_sel),
      .wdata(host_wdata), .q(station_addr));
   nic_byte_array #(.N(HASH_BYTES)) u_hash (
      .clk(clk), .rst_n(rst_n), .we(reg_we && hash_win), .sel(host_addr[2:0]),
      .wdata(host_wdata), .q(mcast_hash));

   // ---------------- read mux ----------------
   always_comb begin
      host_rdata = 8'h00;
      if (host_addr == 4'h0) begin
         host_rdata = cmd_q;
      end else if (sta_win) begin
         host_rdata = station_addr[sta_sel*8 +: 8];
      end else if (hash_win) begin
         host_rdata = mcast_hash[host_addr[2:0]*8 +: 8];
      end else begin
         case (idx)
            IX_BND:    host_rdata = bound_pg;
            IX_TPG:    host_rdata = tsr_q;
            IX_STAT:   host_rdata = stat_q;
            IX_RADR0:  host_rdata = rdma_addr[7:0];
            IX_RADR1:  host_rdata = rdma_addr[15:8];
            IX_RLEN0:  host_rdata = ID0_VAL;
            IX_RLEN1:  host_rdata = ID1_VAL;
            IX_CUR:    host_rdata = cur_pg;
            IX_RSTART: host_rdata = ring_start_pg;
            IX_RSTOP:  host_rdata = ring_stop_pg;
            default:   host_rdata = 8'h00;
         endcase
      end
   end

   // page 3 holds nothing but the command register
   assert_page3_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr != 4'h0 && cmd_q[7:6] == 2'b11) |-> (host_rdata == 8'h00));
endmodule

// File: tb/sim_nic_reg_bank.sv
module sim_nic_reg_bank;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        irq, rx_ok = 1'b0, rdma_done = 1'b0, tx_req, rdma_start;
   logic [7:0]  ring_start_pg, ring_stop_pg, bound_pg, cur_pg, tx_pg, rx_mode, data_mode;
   logic [15:0] tx_len, rdma_addr, rdma_len;
   logic [47:0] station_addr;
   logic [63:0] mcast_hash;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   nic_reg_bank u0 (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
      .rx_ok(rx_ok), .rdma_done(rdma_done), .tx_req(tx_req), .rdma_start(rdma_start),
      .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg), .bound_pg(bound_pg),
      .cur_pg(cur_pg), .tx_pg(tx_pg), .tx_len(tx_len), .rdma_addr(rdma_addr),
      .rdma_len(rdma_len), .rx_mode(rx_mode), .data_mode(data_mode),
      .station_addr(station_addr), .mcast_hash(mcast_hash));

   // scoreboard of expected read bytes
   string      tag_q[$];
   logic [7:0] exp_q[$];
   bit         rd_pend = 1'b0;

   always @(negedge clk) begin
      #2;
      if (rd_pend && exp_q.size() > 0) begin
         automatic string      t = tag_q.pop_front();
         automatic logic [7:0] e = exp_q.pop_front();
         checks++;
         if (host_rdata !== e) begin
            errors++;
            $display("FAIL %s rdata act=%h exp=%h", t, host_rdata, e);
         end
      end
   end

   task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", t, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
      @(negedge clk);
      host_addr = a;
      tag_q.push_back(t); exp_q.push_back(e);
      rd_pend = 1'b1;
      @(posedge clk);
      rd_pend = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      do_reset();
      // reset state
      rd(4'h0, 8'h01, "R1 cmd after reset");
      rd(4'h7, 8'h80, "R1 status after reset");
      rd(4'h3, 8'h00, "R1 boundary after reset");
      #1 chk("R1 irq low", irq, 0);
      chk("R1 ring_start zero", ring_start_pg, 0);

      // mask everything; bit 7 alone must stay quiet
      wr(4'hF, 8'hFF);
      chk("R3 bit7 no irq", irq, 0);

      // stop clear removes bit 7
      wr(4'h0, 8'h22);
      rd(4'h7, 8'h00, "R5 bit7 cleared by start");
      rd(4'h0, 8'h22, "R2 cmd readback");

      // zero-length remote read
      wr(4'h0, 8'h0A);
      chk("R6 no dma start at zero len", rdma_start, 0);
      chk("R3 irq on bit6", irq, 1);
      rd(4'h7, 8'h40, "R6 zero len completes");
      wr(4'h7, 8'hC0);
      rd(4'h7, 8'h00, "R4 w1c");
      #1 chk("R4 irq drops", irq, 0);

      // nonzero remote write
      wr(4'hA, 8'h10);
      wr(4'hB, 8'h02);
      chk("R10 rdma_len", rdma_len, 16'h0210);
      wr(4'h0, 8'h12);
      chk("R6 dma start pulse", rdma_start, 1);
      rd(4'h7, 8'h00, "R6 no bit6 with length");
      #1 chk("R6 pulse one cycle", rdma_start, 0);

      // split halves
      wr(4'h8, 8'h34);
      wr(4'h9, 8'h12);
      rd(4'h8, 8'h34, "R10 radr lo");
      rd(4'h9, 8'h12, "R10 radr hi");
      wr(4'h8, 8'h78);
      #1 chk("R10 lo only", rdma_addr, 16'h1278);
      wr(4'h5, 8'h3C);
      wr(4'h6, 8'h05);
      chk("R10 tx_len", tx_len, 16'h053C);

      // ring limits (end page 0x80)
      wr(4'h1, 8'h46);
      wr(4'h1, 8'h81);
      wr(4'h2, 8'h80);
      wr(4'h2, 8'h81);
      wr(4'h3, 8'h80);
      chk("R8 boundary rejects end", bound_pg, 0);
      wr(4'h3, 8'h7F);
      chk("R8 start keeps", ring_start_pg, 8'h46);
      chk("R8 stop accepts end", ring_stop_pg, 8'h80);
      rd(4'h3, 8'h7F, "R8 boundary below end");
      wr(4'h0, 8'hA2);
      rd(4'h1, 8'h46, "R9 page2 start");
      rd(4'h2, 8'h80, "R9 page2 stop");

      // page 1
      wr(4'h0, 8'h62);
      wr(4'h7, 8'h80);
      rd(4'h7, 8'h00, "R8 cur rejects end");
      wr(4'h7, 8'h4C);
      rd(4'h7, 8'h4C, "R8 cur accepted");
      for (int k = 1; k <= 6; k++) wr(4'(k), 8'hA0 + 8'(k - 1));
      rd(4'h4, 8'hA3, "R11 station byte3");
      chk("R11 station port", station_addr, 48'hA5A4A3A2A1A0);
      wr(4'h8, 8'h11);
      wr(4'hF, 8'h88);
      rd(4'hF, 8'h88, "R11 hash byte7");
      chk("R11 hash low", mcast_hash[7:0], 8'h11);
      chk("R11 hash high", mcast_hash[63:56], 8'h88);

      // page 3
      wr(4'h0, 8'hE2);
      rd(4'h5, 8'h00, "R13 page3 empty");
      rd(4'h0, 8'hE2, "R2 cmd on page3");

      // identity and undefined on page 0
      wr(4'h0, 8'h22);
      rd(4'hA, 8'h50, "R9 id0");
      rd(4'hB, 8'h43, "R9 id1");
      rd(4'hC, 8'h00, "R13 undefined read");

      // transmit
      wr(4'h4, 8'h40);
      chk("R7 tx_pg", tx_pg, 8'h40);
      wr(4'h0, 8'h26);
      chk("R7 tx_req pulse", tx_req, 1);
      rd(4'h4, 8'h01, "R7 tsr ok");
      #1 chk("R7 tx_req one cycle", tx_req, 0);
      rd(4'h0, 8'h22, "R7 tx bit self clears");
      rd(4'h7, 8'h02, "R7 status bit1");
      #1 chk("R3 irq on bit1", irq, 1);
      wr(4'hF, 8'h00);
      chk("R3 masked", irq, 0);
      wr(4'hF, 8'hFF);
      wr(4'h7, 8'h02);

      // side-band events
      @(negedge clk); rx_ok = 1'b1;
      @(negedge clk); rx_ok = 1'b0;
      rd(4'h7, 8'h01, "R12 rx event");
      @(negedge clk);
      host_addr = 4'h7; host_wdata = 8'h01; host_wr = 1'b1; rx_ok = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; rx_ok = 1'b0;
      rd(4'h7, 8'h01, "R12 set beats clear");
      @(negedge clk); rdma_done = 1'b1;
      @(negedge clk); rdma_done = 1'b0;
      rd(4'h7, 8'h41, "R12 dma event");
      wr(4'h7, 8'hFF);
      rd(4'h7, 8'h00, "R4 clear all");

      // bit 7 protection after a fresh reset
      do_reset();
      rd(4'h7, 8'h80, "R1 status after second reset");
      wr(4'h7, 8'hFF);
      rd(4'h7, 8'h80, "R4 bit7 not cleared by w1c");
      wr(4'h0, 8'h03);
      rd(4'h7, 8'h80, "R5 stop keeps bit7");
      wr(4'h0, 8'h22);
      rd(4'h7, 8'h00, "R5 start clears bit7");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule